// File: doc/BRIEF.md
# Indexed Tile Scatter-Store Engine

This engine copies a two-dimensional source tile, held in a local buffer, out to a destination memory. It takes the destination address of each element from a second tile of 32-bit indices. In per-element mode, every source element has its own index. In per-row mode, one index per row names a destination row, and the whole source row lands there.

Each store is either a plain write or an atomic read-modify-write that adds, takes the signed maximum or takes the signed minimum. Elements are visited in row-major order. Each access completes before the next begins, so duplicate destinations resolve to the element visited last.

A single `start_i` pulse latches the job configuration. The engine checks the element type, operation and row alignment before it touches memory. It ends every job with a one-cycle `done_o`, and `err_o` tells whether the job was rejected.

Top module: `tile_scatter`

## Requirements
- R1: In per-element mode (`idx_mode_i`=1), element (i, j) is read from source and index tile address i*cols+j and stored at `base_i` + index.
- R2: In per-row mode (`idx_mode_i`=0), the index is read from index tile address i, and element (i, j) is stored at `base_i` + index*cols + j.
- R3: Elements are visited row by row, columns ascending, rows ascending. When two elements share a destination, the later one decides the final value.
- R4: Only columns j < `vcols_i` are accessed. Destination words that no valid element maps to keep their contents.
- R5: Element type codes are 0 s8, 1 u8, 2 s16, 3 u16, 4 s32 and 5 u32. The stored word is the low 8, 16 or 32 bits of the source word, zero-extended.
- R6: A memory request, with its address, direction and write data, is held unchanged until `mem_ready_i` accepts it.
- R7: Operation codes are 0 store, 1 add, 2 signed max and 3 signed min. In codes 1 to 3, each element reads its destination, waits for `mem_rvalid_i`, and then writes the combined value before the next element starts. Add wraps modulo 2^32. Reads are issued only in codes 1 to 3.
- R8: Some jobs are illegal. Add requires type 4 or 5. Max and min require type 4. Type codes above 5 are illegal, cols times the element byte size must be a multiple of 32, and `vcols_i` must not exceed `cols_i`. An illegal job sets `err_o` and issues no memory access.
- R9: `done_o` is high for exactly one cycle. For a job that makes writes, that cycle follows the acceptance of the last write. Illegal jobs and empty jobs (zero rows or zero valid columns) also end with one `done_o` cycle.
- R10: An index is a 32-bit linear element offset with no bounds check. The address wraps modulo 2^`ADDR_W`, so a negative index lands below `base_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job start pulse, taken when idle |
| rows_i | input | ROW_W | Row count |
| cols_i | input | COL_W | Tile row pitch in elements, also the destination row width |
| vcols_i | input | COL_W | Valid columns per row |
| etype_i | input | 3 | Element type code |
| op_i | input | 2 | Store operation code |
| idx_mode_i | input | 1 | 0 per-row index, 1 per-element index |
| base_i | input | ADDR_W | Destination base address |
| done_o | output | 1 | Job end pulse |
| err_o | output | 1 | Last job was rejected |
| src_addr_o | output | TA_W | Source tile read address |
| src_data_i | input | 32 | Source tile data, one cycle after address |
| idx_addr_o | output | TA_W | Index tile read address |
| idx_data_i | input | 32 | Index tile data, one cycle after address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Memory element address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench builds the engine with `ADDR_W`=8, `ROW_W`=4 and `COL_W`=6. An 8-bit address space lets a 256-word memory model cover every destination the engine can reach. It also makes address wrap from negative indices and large row offsets reachable. A 6-bit column field still allows the 32-column rows that an 8-bit type needs for alignment. Periodic deassertion of `mem_ready_i` exercises request holding during both plain and atomic jobs.

// File: rtl/scat_pkg.sv
package scat_pkg;
  typedef enum logic [2:0] {
    ET_S8 = 3'd0, ET_U8 = 3'd1, ET_S16 = 3'd2, ET_U16 = 3'd3, ET_S32 = 3'd4, ET_U32 = 3'd5
  } etype_e;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0, OP_ADD = 2'd1, OP_MAX = 2'd2, OP_MIN = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CAP, S_WR, S_RD, S_RWAIT, S_DONE
  } state_e;

  function automatic logic [31:0] width_mask(logic [2:0] et);
    case (et)
      3'd0, 3'd1: width_mask = 32'h0000_00ff;
      3'd2, 3'd3: width_mask = 32'h0000_ffff;
      default:    width_mask = 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/scat_cfg_check.sv
module scat_cfg_check
  import scat_pkg::*;
#(
  parameter int COL_W = 6
) (
  input  logic [2:0]       etype_i,
  input  logic [1:0]       op_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic [COL_W-1:0] vcols_i,
  output logic             legal_o
);
  logic type_ok, op_ok, align_ok;

  always_comb begin
    type_ok  = (etype_i <= 3'd5);
    align_ok = 1'b0;
    case (etype_i)
      3'd0, 3'd1: align_ok = (cols_i % COL_W'(32)) == '0;
      3'd2, 3'd3: align_ok = (cols_i % COL_W'(16)) == '0;
      default:    align_ok = (cols_i % COL_W'(8)) == '0;
    endcase
    case (op_i)
      OP_ADD:        op_ok = (etype_i == ET_S32) || (etype_i == ET_U32);
      OP_MAX, OP_MIN: op_ok = (etype_i == ET_S32);
      default:       op_ok = 1'b1;
    endcase
    legal_o = type_ok && op_ok && align_ok && (vcols_i <= cols_i);
  end
endmodule

// File: rtl/scat_walker.sv
module scat_walker #(
  parameter int ROW_W = 4,
  parameter int COL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] vcols_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic row_end;

  assign row_end = (col_o == vcols_i - COL_W'(1));
  assign last_o  = row_end && (row_o == rows_i - ROW_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else if (load_i) begin
      row_o <= '0;
      col_o <= '0;
    end else if (step_i) begin
      if (row_end) begin
        col_o <= '0;
        row_o <= row_o + ROW_W'(1);
      end else begin
        col_o <= col_o + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/scat_alu.sv
module scat_alu
  import scat_pkg::*;
(
  input  logic [1:0]  op_i,
  input  logic [31:0] old_i,
  input  logic [31:0] new_i,
  output logic [31:0] res_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  res_o = old_i + new_i;
      OP_MAX:  res_o = ($signed(new_i) > $signed(old_i)) ? new_i : old_i;
      OP_MIN:  res_o = ($signed(new_i) < $signed(old_i)) ? new_i : old_i;
      default: res_o = new_i;
    endcase
  end
endmodule

// File: rtl/tile_scatter.sv
module tile_scatter
  import scat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 6,
  localparam int TA_W  = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic [COL_W-1:0]  vcols_i,
  input  logic [2:0]        etype_i,
  input  logic [1:0]        op_i,
  input  logic              idx_mode_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              done_o,
  output logic              err_o,
  output logic [TA_W-1:0]   src_addr_o,
  input  logic [31:0]       src_data_i,
  output logic [TA_W-1:0]   idx_addr_o,
  input  logic [31:0]       idx_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i
);
  state_e state_q;

  logic [ROW_W-1:0]  rows_q;
  logic [COL_W-1:0]  cols_q, vcols_q;
  logic [2:0]        etype_q;
  logic [1:0]        op_q;
  logic              mode_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;

  logic              legal, empty, load, step, last;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [TA_W-1:0]   elem_addr;
  logic [31:0]       lin_off;
  logic [31:0]       alu_res;

  scat_cfg_check #(.COL_W(COL_W)) u_chk (
    .etype_i (etype_i),
    .op_i    (op_i),
    .cols_i  (cols_i),
    .vcols_i (vcols_i),
    .legal_o (legal)
  );

  assign empty = (rows_i == '0) || (vcols_i == '0);
  assign load  = (state_q == S_IDLE) && start_i;
  assign step  = (state_q == S_WR) && mem_ready_i && !last;

  scat_walker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .rows_i  (rows_q),
    .vcols_i (vcols_q),
    .row_o   (row),
    .col_o   (col),
    .last_o  (last)
  );

  scat_alu u_alu (
    .op_i  (op_q),
    .old_i (mem_rdata_i),
    .new_i (data_q),
    .res_o (alu_res)
  );

  assign elem_addr  = TA_W'(row) * TA_W'(cols_q) + TA_W'(col);
  assign src_addr_o = elem_addr;
  assign idx_addr_o = mode_q ? elem_addr : TA_W'(row);
  // per-row mode: index names a destination row of width cols
  assign lin_off    = mode_q ? idx_data_i : idx_data_i * 32'(cols_q) + 32'(col);

  assign done_o      = (state_q == S_DONE);
  assign mem_req_o   = (state_q == S_WR) || (state_q == S_RD);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rows_q  <= '0;
      cols_q  <= '0;
      vcols_q <= '0;
      etype_q <= '0;
      op_q    <= '0;
      mode_q  <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      err_o   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          rows_q  <= rows_i;
          cols_q  <= cols_i;
          vcols_q <= vcols_i;
          etype_q <= etype_i;
          op_q    <= op_i;
          mode_q  <= idx_mode_i;
          base_q  <= base_i;
          err_o   <= !legal;
          state_q <= (!legal || empty) ? S_DONE : S_FETCH;
        end
        S_FETCH: state_q <= S_CAP;
        S_CAP: begin
          addr_q  <= base_q + lin_off[ADDR_W-1:0];
          data_q  <= src_data_i & width_mask(etype_q);
          state_q <= (op_q == OP_STORE) ? S_WR : S_RD;
        end
        S_RD:    if (mem_ready_i) state_q <= S_RWAIT;
        S_RWAIT: if (mem_rvalid_i) begin
          data_q  <= alu_res;
          state_q <= S_WR;
        end
        S_WR: if (mem_ready_i) state_q <= last ? S_DONE : S_FETCH;
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);
  // R7
  read_atomic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (op_q != OP_STORE));
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R4
  col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (col < vcols_q));
endmodule

// File: tb/tile_scatter_test.sv
`timescale 1ns/1ps
module tile_scatter_test;
  localparam int ADDR_W = 8;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 6;
  localparam int TA_W   = ROW_W + COL_W;
  localparam int MEM_N  = 1 << ADDR_W;
  localparam int TILE_N = 1 << TA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start = 1'b0;
  logic [ROW_W-1:0]  rows = '0;
  logic [COL_W-1:0]  cols = '0, vcols = '0;
  logic [2:0]        etype = '0;
  logic [1:0]        op = '0;
  logic              mode = 1'b0;
  logic [ADDR_W-1:0] base = '0;
  logic              done, err;
  logic [TA_W-1:0]   src_addr, idx_addr;
  logic [31:0]       src_data, idx_data;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic              mem_ready;
  logic              mem_rvalid = 1'b0;
  logic [31:0]       mem_rdata = '0;

  tile_scatter #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rows_i(rows), .cols_i(cols),
    .vcols_i(vcols), .etype_i(etype), .op_i(op), .idx_mode_i(mode), .base_i(base),
    .done_o(done), .err_o(err), .src_addr_o(src_addr), .src_data_i(src_data),
    .idx_addr_o(idx_addr), .idx_data_i(idx_data), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  logic [31:0] src_t [TILE_N];
  logic [31:0] idx_t [TILE_N];
  logic [31:0] mem   [MEM_N];
  logic [31:0] exp_m [MEM_N];
  int          wr_cnt = 0;
  int          cyc = 0;
  logic        stall_en = 1'b0;
  int          n_run = 0, n_fail = 0;

  assign mem_ready = !stall_en || (cyc % 3 != 0);

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    src_data <= src_t[src_addr];
    idx_data <= idx_t[idx_addr];
    mem_rvalid <= 1'b0;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr];
      end
    end
  end

  initial begin
    #500000;
    n_fail = n_fail + 1;
    $display("FAIL watchdog expired: actual hung, expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run = n_run + 1;
    if (act !== expv) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic clear_all();
    for (int k = 0; k < MEM_N; k++) begin
      mem[k] = 32'hdead_0000 | k;
      exp_m[k] = 32'hdead_0000 | k;
    end
    for (int k = 0; k < TILE_N; k++) begin
      src_t[k] = 32'h5000_0000 + k;
      idx_t[k] = '0;
    end
  endtask

  function automatic logic legal_cfg(input int c, input int vc, input int et, input int o);
    int bytes;
    bytes = (et < 2) ? 1 : (et < 4) ? 2 : 4;
    if (et > 5) return 1'b0;
    if (((c * bytes) % 32) != 0) return 1'b0;
    if (vc > c) return 1'b0;
    if (o == 1 && !(et == 4 || et == 5)) return 1'b0;
    if (o >= 2 && et != 4) return 1'b0;
    return 1'b1;
  endfunction

  task automatic build_expect(input int r, input int c, input int vc, input int et,
                              input int o, input logic md, input int b);
    logic [31:0] msk, v, off, old;
    int a;
    msk = (et < 2) ? 32'hff : (et < 4) ? 32'hffff : 32'hffff_ffff;
    for (int i = 0; i < r; i++)
      for (int j = 0; j < vc; j++) begin
        off = md ? idx_t[i*c+j] : idx_t[i] * c + j;
        a   = (b + off) % MEM_N;
        v   = src_t[i*c+j] & msk;
        old = exp_m[a];
        case (o)
          1: exp_m[a] = old + v;
          2: exp_m[a] = ($signed(v) > $signed(old)) ? v : old;
          3: exp_m[a] = ($signed(v) < $signed(old)) ? v : old;
          default: exp_m[a] = v;
        endcase
      end
  endtask

  task automatic run_job(input string tag, input int r, input int c, input int vc,
                         input int et, input int o, input logic md, input int b);
    int w0, mism, first_bad;
    logic lg;
    lg = legal_cfg(c, vc, et, o);
    if (lg) build_expect(r, c, vc, et, o, md, b);
    w0 = wr_cnt;
    @(negedge clk);
    rows = ROW_W'(r); cols = COL_W'(c); vcols = COL_W'(vc);
    etype = 3'(et); op = 2'(o); mode = md; base = ADDR_W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk({tag, " R8 err flag"}, {31'd0, err}, {31'd0, !lg});
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, {31'd0, done}, 32'd0);
    if (!lg) chk({tag, " R8 no writes"}, wr_cnt - w0, 32'd0);
    mism = 0; first_bad = 0;
    for (int k = MEM_N - 1; k >= 0; k--)
      if (mem[k] !== exp_m[k]) begin mism++; first_bad = k; end
    if (mism != 0)
      chk({tag, " memory word"}, mem[first_bad], exp_m[first_bad]);
    else
      chk({tag, " memory image"}, 32'd0, 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R6 reset req", {31'd0, mem_req}, 32'd0);
    chk("R8 reset err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_elem_store();
    clear_all();
    for (int k = 0; k < 24; k++) idx_t[k] = (k * 7) % 64;
    run_job("R1 elem store s32", 3, 8, 8, 4, 0, 1'b1, 16);
  endtask

  task automatic t_row_store();
    clear_all();
    idx_t[0] = 2; idx_t[1] = 0; idx_t[2] = 5;
    run_job("R2 row store u16", 3, 16, 16, 3, 0, 1'b0, 8);
  endtask

  task automatic t_partial_cols();
    clear_all();
    idx_t[0] = 1; idx_t[1] = 3;
    run_job("R4 partial cols", 2, 8, 5, 5, 0, 1'b0, 0);
    chk("R4 skipped column untouched", mem[8+5], 32'hdead_0000 | (8+5));
  endtask

  task automatic t_dup_last_wins();
    clear_all();
    for (int k = 0; k < 16; k++) idx_t[k] = k % 3;
    stall_en = 1'b1;
    run_job("R3 dup store", 2, 8, 8, 4, 0, 1'b1, 100);
    stall_en = 1'b0;
    chk("R3 last writer", mem[100], src_t[15]);
  endtask

  task automatic t_atomic_add();
    clear_all();
    for (int k = 0; k < 16; k++) begin idx_t[k] = k % 4; src_t[k] = 32'hffff_fff0 + k; end
    stall_en = 1'b1;
    run_job("R7 atomic add", 2, 8, 8, 5, 1, 1'b1, 200);
    stall_en = 1'b0;
  endtask

  task automatic t_atomic_maxmin();
    clear_all();
    for (int k = 0; k < 8; k++) begin idx_t[k] = k % 2; src_t[k] = (k % 3 == 0) ? -k - 5 : k * 1000; end
    mem[50] = 32'h8000_0010; exp_m[50] = 32'h8000_0010;
    run_job("R7 atomic max", 1, 8, 8, 4, 2, 1'b1, 50);
    run_job("R7 atomic min", 1, 8, 8, 4, 3, 1'b1, 60);
  endtask

  task automatic t_illegal();
    clear_all();
    for (int k = 0; k < 64; k++) idx_t[k] = k;
    run_job("R8 add on s16", 2, 16, 16, 2, 1, 1'b1, 0);
    run_job("R8 max on u32", 1, 8, 8, 5, 2, 1'b1, 0);
    run_job("R8 misaligned u8", 1, 16, 16, 1, 0, 1'b1, 0);
    run_job("R8 vcols over cols", 1, 8, 9, 4, 0, 1'b1, 0);
  endtask

  task automatic t_byte_mask();
    clear_all();
    for (int k = 0; k < 32; k++) begin idx_t[k] = 31 - k; src_t[k] = 32'h1234_5680 + k; end
    run_job("R5 u8 mask", 1, 32, 32, 1, 0, 1'b1, 64);
    chk("R5 byte value", mem[64+31], 32'h0000_0080);
  endtask

  task automatic t_neg_wrap();
    clear_all();
    idx_t[0] = 32'hffff_ffff; idx_t[1] = 32'h0000_0103;
    run_job("R10 wrap", 2, 8, 1, 4, 0, 1'b0, 16);
    chk("R10 negative row lands below base", mem[8'(16 - 8)], src_t[0]);
  endtask

  task automatic t_empty();
    int w0;
    clear_all();
    w0 = wr_cnt;
    run_job("R9 empty job", 0, 8, 8, 4, 0, 1'b1, 0);
    chk("R9 empty no writes", wr_cnt - w0, 32'd0);
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_elem_store();
    t_row_store();
    t_partial_cols();
    t_dup_last_wins();
    t_atomic_add();
    t_atomic_maxmin();
    t_illegal();
    t_byte_mask();
    t_neg_wrap();
    t_empty();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule